// File: doc/BRIEF.md
# Timer Channel Compare Output Generator

This block forms one output channel of a general-purpose timer. Each clock it compares the running counter value against the channel's compare value. A three-bit mode field sets how the channel's internal prepare level reacts. The prepare level can keep its value, go high, go low or flip on a match. It can also be pinned low or high whatever the counter does. In the two pulse-width modes it follows how the counter compares with the compare value.

The prepare level drives an output pin and, on the first channel of a timer only, a complementary pin. Each pin has its own enable and its own polarity select. The two pins are derived so that they can never both be in their active state. A one-clock match flag reports every cycle in which the counter equalled the compare value, whatever the mode. Instances built without the complementary capability hold the complementary pin at its inactive level.

Top module: `tmr_chan_out`

## Requirements
- R1: While reset is asserted, and after it is released, the prepare level `prep` and the match flag `match_flag` read 0 until the first clock edge that acts on them.
- R2: With `mode` = 3'b000, `prep` keeps its level at every clock edge, whether or not the counter equals the compare value.
- R3: With `mode` = 3'b001, `prep` becomes 1 at a clock edge where `cnt_val` equals `cmp_val`. With `mode` = 3'b010, it becomes 0 at such an edge. In both modes `prep` is unchanged at edges with no match.
- R4: With `mode` = 3'b011, `prep` inverts at every clock edge where `cnt_val` equals `cmp_val`, and is unchanged at other edges.
- R5: With `mode` = 3'b100, `prep` becomes 0 at the next edge. With `mode` = 3'b101, it becomes 1. Neither depends on the counter or compare values.
- R6: With `mode` = 3'b110, `prep` after an edge equals (`cnt_val` < `cmp_val`) sampled at that edge, unsigned. With `mode` = 3'b111, it is the inverse, (`cnt_val` >= `cmp_val`). Count direction has no effect.
- R7: `match_flag` is 1 for exactly the clock after each edge at which `cnt_val` equalled `cmp_val`, in all eight modes, including the forced ones.
- R8: A polarity bit of 0 makes the active pin level 1, and a polarity bit of 1 makes it 0. With `pri_en` = 1, `ch_out` = `prep` XOR `pri_pol`. With `pri_en` = 0, `ch_out` = `pri_pol`. With `cmp_en` = 1, `ch_outn` = (NOT `prep`) XOR `cmp_pol`. With `cmp_en` = 0, `ch_outn` = `cmp_pol`.
- R9: `ch_out` and `ch_outn` are never both at their active levels at the same time, for any enables and polarities.
- R10: A new `mode` value acts on `prep` at the first clock edge after it is applied, and not before.
- R11: An instance with `HAS_COMP` = 0 drives `ch_outn` to `cmp_pol` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_val | input | CNT_W | Current counter value |
| cmp_val | input | CNT_W | Channel compare value |
| mode | input | 3 | Prepare-level mode select |
| pri_en | input | 1 | Primary pin enable |
| pri_pol | input | 1 | Primary pin polarity, 1 = active low |
| cmp_en | input | 1 | Complementary pin enable |
| cmp_pol | input | 1 | Complementary pin polarity, 1 = active low |
| prep | output | 1 | Registered prepare level |
| match_flag | output | 1 | One-clock compare-match flag |
| ch_out | output | 1 | Primary output pin |
| ch_outn | output | 1 | Complementary output pin |

## Verification
The hardest state to reach from the ports is a toggle or hold mode acting on a prepare level that an earlier mode has left. Reaching it needs a run of cycles in which both the mode and the counter change together. The stimulus table is therefore one ordered walk. In it, set and clear build a known level, consecutive toggles on repeated matches flip it, and hold freezes it. The pulse-width modes are then checked at the counter values just below, at and above the compare value, and at both ends of the counter range. The pin stage is swept through all sixteen enable and polarity combinations at both prepare levels.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

  typedef enum logic [2:0] {
    OCM_HOLD     = 3'b000,
    OCM_SET      = 3'b001,
    OCM_CLR      = 3'b010,
    OCM_TGL      = 3'b011,
    OCM_FORCE_LO = 3'b100,
    OCM_FORCE_HI = 3'b101,
    OCM_PWM_A    = 3'b110,
    OCM_PWM_B    = 3'b111
  } ocm_mode_e;

  typedef struct packed {
    logic eq;
    logic lt;
  } cmp_res_t;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
  import tmr_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  output cmp_res_t         res
);
  always_comb begin
    res.eq = (cnt_val == cmp_val);
    res.lt = (cnt_val <  cmp_val);
  end
endmodule

// File: rtl/tmr_prep_gen.sv
module tmr_prep_gen
  import tmr_cmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [2:0] mode,
  input  cmp_res_t  res,
  output logic      prep,
  output logic      match_flag
);
  ocm_mode_e mode_e;
  logic      prep_q, prep_d, prep_ld;
  logic      flag_q, flag_d, flag_ld;

  always_comb begin
    mode_e = ocm_mode_e'(mode);
    prep_d = prep_q;
    unique case (mode_e)
      OCM_HOLD:     prep_d = prep_q;
      OCM_SET:      prep_d = res.eq ? 1'b1 : prep_q;
      OCM_CLR:      prep_d = res.eq ? 1'b0 : prep_q;
      OCM_TGL:      prep_d = res.eq ? ~prep_q : prep_q;
      OCM_FORCE_LO: prep_d = 1'b0;
      OCM_FORCE_HI: prep_d = 1'b1;
      OCM_PWM_A:    prep_d = res.lt;
      OCM_PWM_B:    prep_d = ~res.lt;
      default:      prep_d = prep_q;
    endcase
    prep_ld = prep_d ^ prep_q;
    flag_d  = res.eq;
    flag_ld = flag_d ^ flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prep_q <= 1'b0;
    else if (prep_ld) prep_q <= prep_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ld) flag_q <= flag_d;
  end

  assign prep       = prep_q;
  assign match_flag = flag_q;
endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage #(
  parameter bit HAS_COMP = 1'b1
) (
  input  logic prep,
  input  logic pri_en,
  input  logic pri_pol,
  input  logic cmp_en,
  input  logic cmp_pol,
  output logic ch_out,
  output logic ch_outn
);
  logic pri_act;

  // active-high intent first, polarity applied last before the pin
  assign pri_act = pri_en & prep;
  assign ch_out  = pri_act ^ pri_pol;

  generate
    if (HAS_COMP) begin : g_comp
      logic cmp_act;
      assign cmp_act = cmp_en & ~prep;
      assign ch_outn = cmp_act ^ cmp_pol;
    end else begin : g_no_comp
      logic unused_en;
      assign unused_en = cmp_en;
      assign ch_outn   = cmp_pol;
    end
  endgenerate
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
  import tmr_cmp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit HAS_COMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [2:0]       mode,
  input  logic             pri_en,
  input  logic             pri_pol,
  input  logic             cmp_en,
  input  logic             cmp_pol,
  output logic             prep,
  output logic             match_flag,
  output logic             ch_out,
  output logic             ch_outn
);
  logic     rst_sync_n;
  cmp_res_t res;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tmr_match_unit #(.CNT_W(CNT_W)) u_match (
    .cnt_val (cnt_val),
    .cmp_val (cmp_val),
    .res     (res)
  );

  tmr_prep_gen u_prep (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode       (mode),
    .res        (res),
    .prep       (prep),
    .match_flag (match_flag)
  );

  tmr_out_stage #(.HAS_COMP(HAS_COMP)) u_out (
    .prep    (prep),
    .pri_en  (pri_en),
    .pri_pol (pri_pol),
    .cmp_en  (cmp_en),
    .cmp_pol (cmp_pol),
    .ch_out  (ch_out),
    .ch_outn (ch_outn)
  );
endmodule

// File: rtl/tmr_chan_out_chk.sv
module tmr_chan_out_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cmp_val,
  input logic [2:0]       mode,
  input logic             pri_pol,
  input logic             cmp_pol,
  input logic             prep,
  input logic             match_flag,
  input logic             ch_out,
  input logic             ch_outn
);
  // R9
  excl_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((ch_out ^ pri_pol) && (ch_outn ^ cmp_pol)));

  // R2
  hold_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000) |=> $stable(prep));

  // R3
  set_on_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b001 && cnt_val == cmp_val) |=> prep);

  // R3
  clr_on_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b010 && cnt_val == cmp_val) |=> !prep);

  // R4
  tgl_on_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b011 && cnt_val == cmp_val) |=> (prep != $past(prep)));

  // R5
  force_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b100) |=> !prep);

  // R5
  force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b101) |=> prep);

  // R6
  pwm_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b110) |=> (prep == $past(cnt_val < cmp_val)));

  // R6
  pwm_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b111) |=> (prep == $past(cnt_val >= cmp_val)));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val == cmp_val) |=> match_flag);

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val != cmp_val) |=> !match_flag);
endmodule

bind tmr_chan_out tmr_chan_out_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cnt_val    (cnt_val),
  .cmp_val    (cmp_val),
  .mode       (mode),
  .pri_pol    (pri_pol),
  .cmp_pol    (cmp_pol),
  .prep       (prep),
  .match_flag (match_flag),
  .ch_out     (ch_out),
  .ch_outn    (ch_outn)
);

// File: tb/tmr_chan_out_tb.sv
module tmr_chan_out_tb;
  localparam int CNT_W = 16;
  localparam int NVEC  = 19;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] cnt_val, cmp_val;
  logic [2:0]       mode;
  logic             pri_en, pri_pol, cmp_en, cmp_pol;
  logic             prep, match_flag, ch_out, ch_outn;
  logic             prep1, flag1, out1, outn1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr_chan_out #(.CNT_W(CNT_W), .HAS_COMP(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_val(cmp_val),
    .mode(mode), .pri_en(pri_en), .pri_pol(pri_pol), .cmp_en(cmp_en),
    .cmp_pol(cmp_pol), .prep(prep), .match_flag(match_flag),
    .ch_out(ch_out), .ch_outn(ch_outn)
  );

  tmr_chan_out #(.CNT_W(CNT_W), .HAS_COMP(1'b0)) u_dut_nc (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_val(cmp_val),
    .mode(mode), .pri_en(pri_en), .pri_pol(pri_pol), .cmp_en(cmp_en),
    .cmp_pol(cmp_pol), .prep(prep1), .match_flag(flag1),
    .ch_out(out1), .ch_outn(outn1)
  );

  // {mode, cnt, cmp, expected prep, expected flag}
  localparam logic [36:0] VEC [NVEC] = '{
    {3'b001, 16'd5,     16'd9,     1'b0, 1'b0},
    {3'b001, 16'd9,     16'd9,     1'b1, 1'b1},
    {3'b000, 16'd9,     16'd9,     1'b1, 1'b1},
    {3'b010, 16'd3,     16'd9,     1'b1, 1'b0},
    {3'b010, 16'd9,     16'd9,     1'b0, 1'b1},
    {3'b011, 16'd9,     16'd9,     1'b1, 1'b1},
    {3'b011, 16'd9,     16'd9,     1'b0, 1'b1},
    {3'b011, 16'd4,     16'd9,     1'b0, 1'b0},
    {3'b011, 16'd9,     16'd9,     1'b1, 1'b1},
    {3'b100, 16'd9,     16'd9,     1'b0, 1'b1},
    {3'b101, 16'd2,     16'd9,     1'b1, 1'b0},
    {3'b110, 16'd3,     16'd9,     1'b1, 1'b0},
    {3'b110, 16'd9,     16'd9,     1'b0, 1'b1},
    {3'b110, 16'd10,    16'd9,     1'b0, 1'b0},
    {3'b111, 16'd3,     16'd9,     1'b0, 1'b0},
    {3'b111, 16'd9,     16'd9,     1'b1, 1'b1},
    {3'b110, 16'd0,     16'd0,     1'b0, 1'b1},
    {3'b111, 16'hFFFF,  16'hFFFF,  1'b1, 1'b1},
    {3'b000, 16'd1,     16'd2,     1'b1, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic [15:0] c, input logic [15:0] k);
    @(negedge clk);
    mode = m; cnt_val = c; cmp_val = k;
    @(posedge clk);
    #2;
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'b000: return "R2";
      3'b001, 3'b010: return "R3";
      3'b011: return "R4";
      3'b100, 3'b101: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 3'b000; cnt_val = '0; cmp_val = 16'd1;
    pri_en = 1'b1; pri_pol = 1'b0; cmp_en = 1'b1; cmp_pol = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1: state under reset
    check("R1 prep", prep, 1'b0);
    check("R1 flag", match_flag, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1 prep after release", prep, 1'b0);
    check("R1 flag after release", match_flag, 1'b0);

    // table walk: R2..R6 per mode, R7 flag, R10 mode acts at next edge
    for (int i = 0; i < NVEC; i++) begin
      logic [36:0] v;
      v = VEC[i];
      step(v[36:34], v[33:18], v[17:2]);
      check(req_of(v[36:34]), prep, v[1]);
      check("R7", match_flag, v[0]);
    end

    // R10: new mode not visible before the edge
    @(negedge clk);
    mode = 3'b100;
    #2;
    check("R10 before edge", prep, 1'b1);
    @(posedge clk); #2;
    check("R10 after edge", prep, 1'b0);

    // R8/R9/R11: pin stage sweep at both prepare levels
    for (int lvl = 0; lvl < 2; lvl++) begin
      step(lvl ? 3'b101 : 3'b100, 16'd7, 16'd8);
      for (int s = 0; s < 16; s++) begin
        logic e_out, e_outn;
        @(negedge clk);
        pri_en = s[0]; pri_pol = s[1]; cmp_en = s[2]; cmp_pol = s[3];
        #2;
        e_out  = pri_en ? (prep ^ pri_pol) : pri_pol;
        e_outn = cmp_en ? (~prep ^ cmp_pol) : cmp_pol;
        check("R8 ch_out", ch_out, (lvl != 0) ? (s[0] ^ s[1]) : s[1]);
        check("R8 ch_outn", ch_outn, (lvl == 0) ? (s[2] ^ s[3]) : s[3]);
        check("R8 model", ch_out, e_out);
        check("R9 exclusive", (ch_out ^ pri_pol) & (ch_outn ^ cmp_pol), 1'b0);
        check("R11 no comp", outn1, s[3]);
      end
    end

    // R7: flag is one clock only
    step(3'b110, 16'd5, 16'd5);
    check("R7 high", match_flag, 1'b1);
    step(3'b110, 16'd6, 16'd5);
    check("R7 single clock", match_flag, 1'b0);

    // R1: asynchronous reset mid-run
    step(3'b101, 16'd1, 16'd1);
    @(negedge clk); rst_n = 1'b0;
    #2;
    check("R1 async prep", prep, 1'b0);
    check("R1 async flag", match_flag, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule